// File: doc/BRIEF.md
# First-Order Fixed-Point Shelving Section

This block is one first-order recursive filter section for audio tone shaping. It has a single real pole and a single real zero, so it acts as a low- or high-frequency shelf that lifts or lowers one end of the spectrum. The three coefficients are constants fixed at elaboration. Each coefficient product is formed by a canonic signed-digit network of shifts and adds, so the section contains no general multiplier.

Samples enter one at a time, each marked by a one-cycle strobe. The section holds the previous input and the previous result in registers, in Direct Form I. It returns each result in a wider word so that a gain of about +6 dB still fits. Every rounding point floors and every overflow wraps. The output is therefore fully determined by the input history and can be compared bit for bit with an arithmetic model.

Top module: `shelf_section`

## Requirements
- R1: While reset is asserted, and directly after it is released, out_data is 0 and out_valid is 0. The stored previous input and previous result are cleared to 0.
- R2: For a strobed sample x[n] (16-bit signed, 15 fraction bits), the section computes y[n] from the previous input x[n-1] and the previous result y[n-1]. The coefficients b1, b2 and a2 are 16-bit signed values with 14 fraction bits. First, N = b1·x[n] + b2·x[n-1] is formed with 30 fraction bits in a 34-bit word. N is then reduced to 29 fraction bits. D = N − a2·y[n-1] is formed with 29 fraction bits in a 34-bit word. Finally, y[n] is D reduced to 15 fraction bits and kept in 18 bits. The result matches this arithmetic exactly.
- R3: Every fraction-bit reduction floors toward negative infinity. With the default coefficients and all state zero, an input of −1 LSB gives y = −2 LSB.
- R4: Overflow wraps. The 34-bit sums keep only their low 34 bits, and y keeps only the low 18 bits of the reduced sum, with no saturation. With b1 = b2 = 32767 and a2 = −32768, an unstable pole, the wrapped results still match R2 exactly.
- R5: The result for the sample taken at strobe k appears on out_data in the cycle after strobe k+1. out_valid is high for exactly that cycle.
- R6: In a cycle without a strobe, in_data is ignored. out_data keeps its value, out_valid is 0 in the following cycle, and the stored state is unchanged, so later results are as if the idle cycle never happened.
- R7: The first strobe after reset does not raise out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_data | input | 16 | Signed input sample, 15 fraction bits |
| out_valid | output | 1 | High for one cycle when out_data carries a new result |
| out_data | output | 18 | Signed result, 15 fraction bits |

## Verification
The stored previous input and previous result feed straight into the next computation. A corrupted state value therefore shows on out_data at the second strobe after the fault, and because of the feedback it keeps propagating after that. A rounding or wrap error changes at most a few LSBs at first. For this reason every output is compared bit-exactly with an independent model, never against a tolerance. The unstable second instance exercises wrapping on almost every sample. Random idle gaps between strobes show any state drift within one further strobe.

// File: rtl/shelf_section.sv
module shelf_section #(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 15,
  parameter int COEF_W   = 16,
  parameter int B_FRAC   = 14,
  parameter int A_FRAC   = 14,
  parameter int NUM_W    = 34,
  parameter int NUM_FRAC = 30,
  parameter int DEN_W    = 34,
  parameter int DEN_FRAC = 29,
  parameter int OUT_W    = 18,
  parameter int OUT_FRAC = 15,
  parameter logic signed [COEF_W-1:0] B1 = 16'sd16499,
  parameter logic signed [COEF_W-1:0] B2 = -16'sd16037,
  parameter logic signed [COEF_W-1:0] A2 = -16'sd16152
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int DIGITS = COEF_W + 1;
  localparam int NUM_SH = NUM_FRAC - IN_FRAC - B_FRAC;
  localparam int QSH    = NUM_FRAC - DEN_FRAC;
  localparam int DEN_SH = DEN_FRAC - OUT_FRAC - A_FRAC;
  localparam int OSH    = DEN_FRAC - OUT_FRAC;

  function automatic logic [31:0] csd_mask(input int c, input int sel);
    int v;
    int d;
    logic [31:0] m;
    v = c;
    m = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[0]) d = v[1] ? -1 : 1;
      else d = 0;
      m[i] = (d == sel);
      v = (v - d) >>> 1;
    end
    return m;
  endfunction

  localparam logic [31:0] B1_P = csd_mask(int'(B1), 1);
  localparam logic [31:0] B1_N = csd_mask(int'(B1), -1);
  localparam logic [31:0] B2_P = csd_mask(int'(B2), 1);
  localparam logic [31:0] B2_N = csd_mask(int'(B2), -1);
  localparam logic [31:0] A2_P = csd_mask(int'(A2), 1);
  localparam logic [31:0] A2_N = csd_mask(int'(A2), -1);

  logic signed [IN_W-1:0]  x_prev;
  logic signed [OUT_W-1:0] y_prev;
  logic                    primed;

  logic signed [NUM_W-1:0] xe, xpe, num_acc;
  logic signed [DEN_W-1:0] ye, num_q, den_acc;
  logic signed [OUT_W-1:0] y_new;

  assign xe  = {{(NUM_W-IN_W){in_data[IN_W-1]}}, in_data};
  assign xpe = {{(NUM_W-IN_W){x_prev[IN_W-1]}}, x_prev};
  assign ye  = {{(DEN_W-OUT_W){y_prev[OUT_W-1]}}, y_prev};

  always_comb begin
    num_acc = '0;
    for (int k = 0; k < DIGITS; k++) begin
      if (B1_P[k]) num_acc = num_acc + (xe <<< (k + NUM_SH));
      if (B1_N[k]) num_acc = num_acc - (xe <<< (k + NUM_SH));
      if (B2_P[k]) num_acc = num_acc + (xpe <<< (k + NUM_SH));
      if (B2_N[k]) num_acc = num_acc - (xpe <<< (k + NUM_SH));
    end
  end

  assign num_q = DEN_W'(num_acc >>> QSH);

  always_comb begin
    den_acc = num_q;
    for (int k = 0; k < DIGITS; k++) begin
      if (A2_P[k]) den_acc = den_acc - (ye <<< (k + DEN_SH));
      if (A2_N[k]) den_acc = den_acc + (ye <<< (k + DEN_SH));
    end
  end

  assign y_new = OUT_W'(den_acc >>> OSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_prev    <= '0;
      y_prev    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      primed    <= 1'b0;
    end else begin
      out_valid <= in_valid & primed;
      if (in_valid) begin
        x_prev   <= in_data;
        y_prev   <= y_new;
        out_data <= y_prev;
        primed   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/shelf_section_chk.sv
module shelf_section_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_data,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data,
  input logic signed [IN_W-1:0]  x_prev,
  input logic signed [OUT_W-1:0] y_prev,
  input logic                    primed
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0 && x_prev == '0 && y_prev == '0));

  p_capture_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> x_prev == $past(in_data));

  p_output_from_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data == $past(y_prev));

  p_valid_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid == $past(primed)));

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(x_prev) && $stable(y_prev) && !out_valid));

  p_first_strobe_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !out_valid);

endmodule

bind shelf_section shelf_section_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data),
  .x_prev(x_prev), .y_prev(y_prev), .primed(primed)
);

// File: tb/sim_shelf_section.sv
module sim_shelf_section;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid, out_valid1;
  logic signed [17:0] out_data, out_data1;

  always #10 clk = ~clk;

  shelf_section u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  shelf_section #(.B1(16'sd32767), .B2(16'sd32767), .A2(-16'sd32768)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid1), .out_data(out_data1));

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  longint mx1[2], my1[2];
  bit mpr[2];
  bit ev[2];
  longint ed[2];
  bit last_v;

  function automatic longint wrapw(longint v, int w);
    longint m;
    m = v & ((64'sd1 <<< w) - 1);
    if (m[w-1]) m = m - (64'sd1 <<< w);
    return m;
  endfunction

  function automatic longint ref_y(longint b1, longint b2, longint a2,
                                   longint x, longint x1, longint y1);
    longint n, d;
    n = wrapw((b1 * x + b2 * x1) <<< 1, 34);
    n = n >>> 1;
    d = wrapw(n - a2 * y1, 34);
    return wrapw(d >>> 14, 18);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      mx1[i] = 0; my1[i] = 0; mpr[i] = 0; ev[i] = 0; ed[i] = 0;
    end
    last_v = 0;
  endtask

  task automatic step(bit v, logic signed [15:0] x, string tag);
    string dt, vt;
    dt = last_v ? tag : "R6";
    vt = (tag == "R7") ? "R7" : (last_v ? "R5" : "R6");
    chk({dt, " u0 data"}, longint'(out_data), ed[0]);
    chk({vt, " u0 valid"}, longint'(out_valid), longint'(ev[0]));
    chk({last_v ? "R4" : "R6", " u1 data"}, longint'(out_data1), ed[1]);
    chk({vt, " u1 valid"}, longint'(out_valid1), longint'(ev[1]));
    in_valid = v;
    in_data = x;
    for (int i = 0; i < 2; i++) begin
      if (v) begin
        longint yn;
        ed[i] = my1[i];
        if (i == 0) yn = ref_y(16499, -16037, -16152, longint'(x), mx1[i], my1[i]);
        else        yn = ref_y(32767, 32767, -32768, longint'(x), mx1[i], my1[i]);
        mx1[i] = longint'(x);
        my1[i] = yn;
        ev[i] = mpr[i];
        mpr[i] = 1;
      end else begin
        ev[i] = 0;
      end
    end
    last_v = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset data", longint'(out_data), 0);
    chk("R1 reset valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release data", longint'(out_data), 0);
    chk("R1 after release valid", longint'(out_valid), 0);

    // R7 first strobe silent, R3 floor of -1 LSB gives -2
    step(1, -16'sd1, "R7");
    step(1, 16'sd0, "R3");
    step(0, 16'sd0, "R3");
    chk("R3 floor result", longint'(out_data), -2);

    // R2 impulse and extremes
    step(1, 16'sd32767, "R2");
    for (int i = 0; i < 20; i++) step(1, 16'sd0, "R2");
    for (int i = 0; i < 30; i++) step(1, -16'sd32768, "R2");
    for (int i = 0; i < 30; i++) step(1, 16'sd32767, "R2");
    // R6 idle cycles with junk on in_data
    for (int i = 0; i < 5; i++) step(0, 16'sh5A5A, "R6");
    step(1, 16'sd100, "R2");
    step(1, 16'sd0, "R2");

    // constrained random mix
    void'($urandom(32'd12345));
    for (int i = 0; i < 3000; i++) begin
      bit v;
      logic signed [15:0] x;
      v = ($urandom % 3) != 0;
      case ($urandom % 4)
        0: x = 16'sd32767;
        1: x = -16'sd32768;
        default: x = 16'($urandom);
      endcase
      step(v, x, "R2");
    end

    // mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset data", longint'(out_data), 0);
    chk("R1 mid reset valid", longint'(out_valid), 0);
    chk("R1 mid reset data u1", longint'(out_data1), 0);
    rst_n = 1'b1;
    model_reset();
    step(1, 16'sd1234, "R7");
    for (int i = 0; i < 40; i++) step(1, 16'(i * 777), "R2");
    step(0, 16'sd0, "R2");
    step(0, 16'sd0, "R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule